// File: doc/BRIEF.md
# LED Column Driver Configuration Sequencer

This block runs once after power-up. It loads the two 16-bit configuration registers of a chain of constant-current LED column drivers that share one panel row. It generates the shift clock, the six color data lines, the latch line and the active-low output enable. While the sequence runs, the block alone owns these pins. When `done_o` rises, the normal scan logic takes them over. The drivers do not decode a register address. They tell the two registers apart by how many shift clocks the latch stays high at the tail of a full-row shift.

The `mode_i` input picks one of two driver families, and the block samples it on the cycle `start_i` is accepted:

- **Falling-edge family** (`mode_i` = 0): the shift clock idles high and the drivers sample on its falling edge. Register bits go out LSB first.
- **Rising-edge family** (`mode_i` = 1): the shift clock idles low and the drivers sample on its rising edge. Register bits go out MSB first. This family also runs a clear pass and a blanking pass.

The row length and the four register words are parameters. The row length must be at least 16.

There is no data stream at the block's edge, so there is no valid/ready handshake. `start_i` is a plain pulse. A pulse that arrives while a sequence is running, or after `done_o` has risen, is dropped. The block never applies back-pressure.

Top module: `panel_cfg_seq`

## Requirements
- R1: After reset and before a start, `oe_n_o`=1, `lat_o`=0, `rgb_o`=0, `done_o`=0 and `sclk_o`=1.
- R2: `start_i` is accepted only when the block is idle and not done. `mode_i` is sampled on that cycle only. Start pulses and mode changes after that cycle have no effect on the pin sequence.
- R3: Each shift clock has two parts. First comes a setup system-clock cycle at the idle level, then a strobe cycle at the active level. For mode 0 the idle level is 1 and the active edge is falling. For mode 1 the idle level is 0 and the active edge is rising. Data and latch change only while the clock is at its idle level.
- R4: On every shift clock all six data lines carry the same bit. In a register write, the bit on clock n is taken at position n mod 16 of the word. For mode 0 that is word bit (n mod 16). For mode 1 it is word bit (15 − n mod 16).
- R5: Every register write lasts ROW_LEN shift clocks. The latch is high on the last 11 clocks of the first-word write and on the last 12 clocks of the second-word write. It is low on the first clock of the next phase.
- R6: The mode 0 order is:
  - first word;
  - second word;
  - ROW_LEN clocks of zero data with the latch low;
  - one clock of zero data with the latch high;
  - one final clock.
  That is 3·ROW_LEN+2 clocks.
- R7: The mode 1 order is:
  - a clear pass of ROW_LEN zero clocks with the latch high on the last 3;
  - first word;
  - second word;
  - one zero clock with the latch low;
  - a blanking pass of ROW_LEN zero clocks with the latch high on the last 3;
  - one final clock.
  That is 4·ROW_LEN+2 clocks.
- R8: `oe_n_o` stays 1 from reset through every shift clock except the final one. It is 0 on the final clock and stays 0 afterwards.
- R9: `done_o` is 0 at every active edge. It rises in the cycle after the final active edge and stays 1 until reset. After that, the clock sits at its idle level and data and latch are 0.
- R10: The default words are:
  - mode 0: first word 0x07E0 (bits 5 to 10), second word 0x0200 (bit 9);
  - mode 1: first word 0x00FF (current gain), second word 0xFF00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins the sequence |
| mode_i | input | 1 | Driver family: 0 falling-edge, 1 rising-edge |
| rgb_o | output | 6 | Color data lines, all carrying the same bit |
| sclk_o | output | 1 | Generated shift clock |
| lat_o | output | 1 | Latch line |
| oe_n_o | output | 1 | Active-low LED output enable |
| done_o | output | 1 | Sequence finished, sticky until reset |

## Verification
The assertions assume that `rst_n` is held low long enough to clear the state. They also assume that the parameter words are constant and that ROW_LEN is at least 16, so the 4-bit word index is always in range. They make no assumption about when `start_i` or `mode_i` toggle.

The stimulus stays inside these assumptions. It changes inputs only on falling system-clock edges. To show that stray starts and mode changes during a run are dropped, it flips `mode_i` right after the accepted start and sends extra start pulses mid-run and after completion.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [2:0] {
    PH_CLEAR = 3'd0,
    PH_WORD1 = 3'd1,
    PH_WORD2 = 3'd2,
    PH_GAP   = 3'd3,
    PH_BLANK = 3'd4,
    PH_PULSE = 3'd5,
    PH_FINAL = 3'd6
  } phase_e;

  typedef enum logic {
    FAM_FALL = 1'b0,
    FAM_RISE = 1'b1
  } fam_e;

  localparam int unsigned WORD_W     = 16;
  localparam int unsigned TAIL_WORD1 = 11;
  localparam int unsigned TAIL_WORD2 = 12;
  localparam int unsigned TAIL_SHORT = 3;

  function automatic phase_e first_phase(fam_e f);
    return (f == FAM_RISE) ? PH_CLEAR : PH_WORD1;
  endfunction

  function automatic phase_e next_phase(fam_e f, phase_e p);
    phase_e n;
    case (p)
      PH_CLEAR: n = PH_WORD1;
      PH_WORD1: n = PH_WORD2;
      PH_WORD2: n = (f == FAM_RISE) ? PH_GAP : PH_BLANK;
      PH_GAP:   n = PH_BLANK;
      PH_BLANK: n = (f == FAM_RISE) ? PH_FINAL : PH_PULSE;
      default:  n = PH_FINAL;
    endcase
    return n;
  endfunction

  function automatic logic full_row(phase_e p);
    return (p == PH_CLEAR) || (p == PH_WORD1) || (p == PH_WORD2) || (p == PH_BLANK);
  endfunction

  function automatic int unsigned tail_len(fam_e f, phase_e p);
    int unsigned t;
    case (p)
      PH_CLEAR: t = TAIL_SHORT;
      PH_WORD1: t = TAIL_WORD1;
      PH_WORD2: t = TAIL_WORD2;
      PH_BLANK: t = (f == FAM_RISE) ? TAIL_SHORT : 0;
      PH_PULSE: t = 1;
      default:  t = 0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pcfg_seq.sv
module pcfg_seq
  import pcfg_pkg::*;
#(
  parameter int unsigned ROW_LEN = 64,
  localparam int unsigned CW = $clog2(ROW_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  output logic          run_o,
  output logic          strobe_o,
  output fam_e          fam_o,
  output phase_e        ph_o,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);

  localparam logic [CW-1:0] LAST_CNT = CW'(ROW_LEN - 1);

  logic          run_q, sub_q, done_q;
  fam_e          fam_q;
  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          last_clk;

  assign last_clk = full_row(ph_q) ? (cnt_q == LAST_CNT) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sub_q  <= 1'b0;
      done_q <= 1'b0;
      fam_q  <= FAM_FALL;
      ph_q   <= PH_WORD1;
      cnt_q  <= '0;
    end else if (!run_q && !done_q) begin
      if (start_i) begin
        run_q <= 1'b1;
        sub_q <= 1'b0;
        fam_q <= fam_e'(mode_i);
        ph_q  <= first_phase(fam_e'(mode_i));
        cnt_q <= '0;
      end
    end else if (run_q) begin
      if (!sub_q) begin
        sub_q <= 1'b1;
      end else begin
        sub_q <= 1'b0;
        if (last_clk) begin
          cnt_q <= '0;
          if (ph_q == PH_FINAL) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ph_q <= next_phase(fam_q, ph_q);
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign run_o    = run_q;
  assign strobe_o = sub_q;
  assign fam_o    = fam_q;
  assign ph_o     = ph_q;
  assign cnt_o    = cnt_q;
  assign done_o   = done_q;

  // R2: family captured at start cannot move while running
  a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(fam_q));

  // R3: a setup cycle is always followed by a strobe cycle
  a_r3_setup_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !sub_q) |=> (run_q && sub_q));

  // R6: phase only advances at the strobe of the last clock of the phase
  a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !(sub_q && last_clk)) |=> $stable(ph_q));

  // R9: done is sticky and the engine never restarts
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (done_q && !run_q));

endmodule

// File: rtl/pcfg_slot.sv
module pcfg_slot
  import pcfg_pkg::*;
#(
  parameter int unsigned ROW_LEN    = 64,
  parameter logic [15:0] FALL_WORD1 = 16'h07E0,
  parameter logic [15:0] FALL_WORD2 = 16'h0200,
  parameter logic [15:0] RISE_WORD1 = 16'h00FF,
  parameter logic [15:0] RISE_WORD2 = 16'hFF00,
  localparam int unsigned CW = $clog2(ROW_LEN)
) (
  input  fam_e          fam_i,
  input  phase_e        ph_i,
  input  logic [CW-1:0] cnt_i,
  output logic          bit_o,
  output logic          lat_o,
  output logic          dark_o
);

  logic [WORD_W-1:0] word_sel;
  logic [WORD_W-1:0] word_rev;
  logic [3:0]        idx;
  logic              loads;

  assign idx   = cnt_i[3:0];
  assign loads = (ph_i == PH_WORD1) || (ph_i == PH_WORD2);

  always_comb begin
    if (fam_i == FAM_RISE)
      word_sel = (ph_i == PH_WORD2) ? RISE_WORD2 : RISE_WORD1;
    else
      word_sel = (ph_i == PH_WORD2) ? FALL_WORD2 : FALL_WORD1;
  end

  for (genvar g = 0; g < WORD_W; g++) begin : g_rev
    assign word_rev[g] = word_sel[WORD_W-1-g];
  end

  assign bit_o = loads & ((fam_i == FAM_RISE) ? word_rev[idx] : word_sel[idx]);

  always_comb begin
    int unsigned tail, plen, pos;
    tail  = tail_len(fam_i, ph_i);
    plen  = full_row(ph_i) ? ROW_LEN : 1;
    pos   = 32'(cnt_i);
    lat_o = (tail != 0) && ((pos + tail) >= plen);
  end

  assign dark_o = (ph_i != PH_FINAL);

endmodule

// File: rtl/pcfg_pins.sv
module pcfg_pins
  import pcfg_pkg::*;
#(
  parameter int unsigned LANES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             strobe_i,
  input  fam_e             fam_i,
  input  logic             done_i,
  input  logic             bit_i,
  input  logic             lat_i,
  input  logic             dark_i,
  output logic [LANES-1:0] rgb_o,
  output logic             sclk_o,
  output logic             lat_o,
  output logic             oe_n_o,
  output logic             done_o
);

  logic [LANES-1:0] rgb_q;
  logic             sclk_q, lat_q, oe_n_q, done_q;
  logic             idle_lvl;

  assign idle_lvl = (fam_i == FAM_FALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q  <= '0;
      sclk_q <= 1'b1;
      lat_q  <= 1'b0;
      oe_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= done_i;
      if (run_i) begin
        rgb_q  <= {LANES{bit_i}};
        lat_q  <= lat_i;
        oe_n_q <= dark_i;
        sclk_q <= strobe_i ? ~idle_lvl : idle_lvl;
      end else begin
        rgb_q  <= '0;
        lat_q  <= 1'b0;
        oe_n_q <= ~done_i;
        sclk_q <= idle_lvl;
      end
    end
  end

  assign rgb_o  = rgb_q;
  assign sclk_o = sclk_q;
  assign lat_o  = lat_q;
  assign oe_n_o = oe_n_q;
  assign done_o = done_q;

  // R3: data and latch move only while the shift clock rests at idle
  a_r3_change_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(rgb_q) || $changed(lat_q)) |-> (sclk_q == idle_lvl));

  // R4: all lanes always agree
  a_r4_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_q == '0) || (rgb_q == '1));

  // R8: display stays dark for every non-final slot
  a_r8_dark_until_final: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && dark_i) |=> oe_n_q);

  // R9: after completion the pins sit quiet with the display enabled
  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!oe_n_q && !lat_q && rgb_q == '0));

endmodule

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq
  import pcfg_pkg::*;
#(
  parameter int unsigned ROW_LEN    = 64,
  parameter logic [15:0] FALL_WORD1 = 16'h07E0,
  parameter logic [15:0] FALL_WORD2 = 16'h0200,
  parameter logic [15:0] RISE_WORD1 = 16'h00FF,
  parameter logic [15:0] RISE_WORD2 = 16'hFF00,
  parameter int unsigned LANES      = 6,
  localparam int unsigned CW = $clog2(ROW_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  output logic [LANES-1:0] rgb_o,
  output logic             sclk_o,
  output logic             lat_o,
  output logic             oe_n_o,
  output logic             done_o
);

  logic          run, strobe, seq_done, bit_v, lat_v, dark_v;
  fam_e          fam;
  phase_e        ph;
  logic [CW-1:0] cnt;

  pcfg_seq #(.ROW_LEN(ROW_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .run_o(run), .strobe_o(strobe), .fam_o(fam), .ph_o(ph),
    .cnt_o(cnt), .done_o(seq_done)
  );

  pcfg_slot #(
    .ROW_LEN(ROW_LEN), .FALL_WORD1(FALL_WORD1), .FALL_WORD2(FALL_WORD2),
    .RISE_WORD1(RISE_WORD1), .RISE_WORD2(RISE_WORD2)
  ) u_slot (
    .fam_i(fam), .ph_i(ph), .cnt_i(cnt),
    .bit_o(bit_v), .lat_o(lat_v), .dark_o(dark_v)
  );

  pcfg_pins #(.LANES(LANES)) u_pins (
    .clk(clk), .rst_n(rst_n), .run_i(run), .strobe_i(strobe), .fam_i(fam),
    .done_i(seq_done), .bit_i(bit_v), .lat_i(lat_v), .dark_i(dark_v),
    .rgb_o(rgb_o), .sclk_o(sclk_o), .lat_o(lat_o), .oe_n_o(oe_n_o),
    .done_o(done_o)
  );

endmodule

// File: tb/sim_panel_cfg_seq.sv
`timescale 1ns/1ps
module sim_panel_cfg_seq;

  localparam int unsigned ROW = 64;

  logic       clk = 1'b0;
  logic       rst_n, start_i, mode_i;
  logic [5:0] rgb_o;
  logic       sclk_o, lat_o, oe_n_o, done_o;

  always #2 clk = ~clk;

  panel_cfg_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .rgb_o(rgb_o), .sclk_o(sclk_o), .lat_o(lat_o), .oe_n_o(oe_n_o),
    .done_o(done_o)
  );

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   tests = 0;
  int   fails = 0;
  int   cycles = 0;
  logic cur_fam = 1'b0;
  logic prev_sclk = 1'b1;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_row(input logic [15:0] w, input logic msb, input int tail, input int len, input string tag);
    for (int n = 0; n < len; n++) begin
      exp_t e;
      logic b, l;
      b   = msb ? w[15 - (n % 16)] : w[n % 16];
      l   = (tail != 0) && (n + tail >= len);
      e.v = {1'b1, l, {6{b}}};
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic push_one(input logic oe_n, input logic l, input string tag);
    exp_t e;
    e.v = {oe_n, l, 6'b0};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // driver side of the scoreboard: expected pixel-clock items per family
  task automatic push_seq(input logic fam);
    if (!fam) begin
      push_row(16'h07E0, 1'b0, 11, ROW, "R4/R5/R10 fall word1");
      push_row(16'h0200, 1'b0, 12, ROW, "R4/R5/R10 fall word2");
      push_row(16'h0000, 1'b0, 0,  ROW, "R6 fall zero row");
      push_one(1'b1, 1'b1, "R6 fall latch pulse");
      push_one(1'b0, 1'b0, "R8 fall final clock");
    end else begin
      push_row(16'h0000, 1'b1, 3,  ROW, "R7 rise clear pass");
      push_row(16'h00FF, 1'b1, 11, ROW, "R4/R5/R10 rise word1");
      push_row(16'hFF00, 1'b1, 12, ROW, "R4/R5/R10 rise word2");
      push_one(1'b1, 1'b0, "R7 rise gap clock");
      push_row(16'h0000, 1'b1, 3,  ROW, "R7 rise blank pass");
      push_one(1'b0, 1'b0, "R8 rise final clock");
    end
  endtask

  // monitor side: pop one item at every active shift-clock edge (R3 orientation)
  always @(negedge clk) begin
    if (rst_n) begin
      logic act;
      act = cur_fam ? (!prev_sclk && sclk_o) : (prev_sclk && !sclk_o);
      if (act) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected shift clock", 32'(sclk_o), 32'(prev_sclk));
        end else begin
          exp_t e;
          logic [7:0] got;
          e   = exp_q.pop_front();
          got = {oe_n_o, lat_o, rgb_o};
          chk(got == e.v, e.tag, 32'(got), 32'(e.v));
          chk(done_o == 1'b0, "R9 done before end", 32'(done_o), 32'd0);
        end
      end
    end
    prev_sclk = sclk_o;
  end

  task automatic do_reset;
    rst_n = 1'b0;
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe_n_o == 1'b1, "R1 oe_n after reset", 32'(oe_n_o), 32'd1);
    chk(lat_o == 1'b0 && rgb_o == 6'd0, "R1 lat/rgb after reset", {25'd0, lat_o, rgb_o}, 32'd0);
    chk(done_o == 1'b0, "R1 done after reset", 32'(done_o), 32'd0);
    chk(sclk_o == 1'b1, "R1 sclk after reset", 32'(sclk_o), 32'd1);
  endtask

  task automatic run_seq(input logic fam, input bit spam);
    int waited;
    cur_fam = fam;
    push_seq(fam);
    @(negedge clk);
    mode_i  = fam;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    mode_i  = ~fam;  // R2: later mode changes must not matter
    if (spam) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    waited = 0;
    while (!done_o && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    chk(done_o == 1'b1, "R9 done raised", 32'(done_o), 32'd1);
    chk(exp_q.size() == 0, fam ? "R7 clock count" : "R6 clock count", 32'(exp_q.size()), 32'd0);
    chk(oe_n_o == 1'b0, "R8 oe_n low after end", 32'(oe_n_o), 32'd0);
    chk(sclk_o == ~fam, "R9 sclk idle after end", 32'(sclk_o), 32'(~fam));
    chk(lat_o == 1'b0 && rgb_o == 6'd0, "R9 lat/rgb quiet", {25'd0, lat_o, rgb_o}, 32'd0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(done_o == 1'b1, "R9 done sticky", 32'(done_o), 32'd1);
    chk(oe_n_o == 1'b0, "R2 start after done ignored", 32'(oe_n_o), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    mode_i = 1'b0;
    do_reset();
    run_seq(1'b0, 1'b0);
    do_reset();
    run_seq(1'b1, 1'b1);
    do_reset();
    run_seq(1'b0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule